// File: doc/BRIEF.md
# I2C Role and Direction Tracker

This block holds the two role flags of an I2C controller: whether it acts as bus master or as slave, and whether it transmits or receives. Firmware loads both flags through a simple write port. After that, the block rewrites them from byte-level bus events. These events are a start, the first byte after a start, an acknowledge received for that byte, a stop, and a loss of arbitration. The block also raises a flag when the first byte carries its own programmed address, and another when the first byte is a general call.

The direction rule depends on the role. A slave takes the direction straight from the received R/W bit, and only when it is actually addressed. A master, once its address byte has been acknowledged, takes the inverse of the R/W bit it sent. In free-data-format mode the hardware leaves the direction flag alone completely. Bit shifting, clock generation and the register bus sit outside this block. A byte-event interface stands in for them.

Top module: `i2c_role_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, all four outputs are 0 after that edge.
- R2: A write (`sw_wr_i`=1) in a cycle with no hardware event loads `mst_o`=`sw_mst_i` and `trx_o`=`sw_trx_i`, visible one cycle later.
- R3: When the first byte arrives (`first_vld_i`) while `mst_o`=0 and `free_fmt_i`=0, and bits [7:1] equal `own_addr_i`, then `addr_hit_o` becomes 1 and `trx_o` takes bit 0 (the R/W bit: 1 = transmit, 0 = receive).
- R4: A first byte of 8'h00 received as a slave in addressing format sets `gen_call_o`=1 and makes `trx_o`=0.
- R5: A slave first byte that neither matches `own_addr_i` nor is 8'h00 leaves `trx_o`, `addr_hit_o` and `gen_call_o` unchanged.
- R6: A master (`mst_o`=1) records the R/W bit of its first byte. On the next `ack_i` strobe, `trx_o` becomes the inverse of that bit.
- R7: As a master, `trx_o` keeps its value while no acknowledge arrives for the address byte. Any `ack_i` after the first one following that byte has no effect on `trx_o`.
- R8: `stop_i` or `arb_lost_i` clears `mst_o`. When `free_fmt_i`=0, it also clears `trx_o`.
- R9: With `free_fmt_i`=1, no hardware event changes `trx_o`, and neither `addr_hit_o` nor `gen_call_o` is set.
- R10: `start_i` or `stop_i` clears `addr_hit_o` and `gen_call_o` one cycle later. The clear wins over a set in the same cycle.
- R11: A write is dropped whole when any of `stop_i`, `arb_lost_i`, `first_vld_i` or `ack_i` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_i | input | 1 | Software write strobe for the role flags |
| sw_mst_i | input | 1 | Master flag value to write |
| sw_trx_i | input | 1 | Transmit flag value to write |
| start_i | input | 1 | Start condition detected strobe |
| first_vld_i | input | 1 | First byte after a start is complete |
| first_byte_i | input | ADDR_W+1 | First byte: address in [ADDR_W:1], R/W in [0] |
| ack_i | input | 1 | Acknowledge received strobe |
| stop_i | input | 1 | Stop condition detected strobe |
| arb_lost_i | input | 1 | Arbitration lost strobe |
| free_fmt_i | input | 1 | Free-data-format mode select |
| own_addr_i | input | ADDR_W | Programmed own slave address |
| mst_o | output | 1 | 1 = master, 0 = slave |
| trx_o | output | 1 | 1 = transmitter, 0 = receiver |
| addr_hit_o | output | 1 | First byte matched the own address |
| gen_call_o | output | 1 | First byte was a general call |

## Verification
The bench targets the role-dependent inversion. A design that used the R/W bit the same way in both roles would end a master read in transmit mode. It checks that only the first acknowledge after the address byte counts. A design that kept listening would flip direction on every data acknowledge. It drives stop and arbitration loss in free-data-format mode, where a careless design would clear the transmit flag. It also collides software writes with hardware events; a design that let the write win would resurrect a master that had just lost arbitration.

// File: rtl/i2c_role_pkg.sv
package i2c_role_pkg;

  localparam int unsigned DEF_ADDR_W = 7;

  typedef enum logic [1:0] {
    TRX_HOLD  = 2'd0,
    TRX_CLEAR = 2'd1,
    TRX_SLAVE = 2'd2,
    TRX_MSTR  = 2'd3
  } trx_src_e;

  function automatic logic is_all_zero(input logic [31:0] v, input int unsigned w);
    logic z;
    z = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < w && v[i]) z = 1'b0;
    end
    return z;
  endfunction

endpackage

// File: rtl/i2c_role_addr_match.sv
module i2c_role_addr_match #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              first_vld_i,
  input  logic [ADDR_W:0]   first_byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              mst_i,
  input  logic              free_fmt_i,
  output logic              slave_sel_o,
  output logic              addr_hit_o,
  output logic              gen_call_o
);
  import i2c_role_pkg::*;

  localparam int unsigned BYTE_W = ADDR_W + 1;

  logic [ADDR_W-1:0] rx_addr;
  logic              eq_own;
  logic              eq_zero;
  logic              eligible;
  logic              hit_set;
  logic              gc_set;
  logic              flag_clr;

  assign rx_addr  = first_byte_i[ADDR_W:1];
  assign eq_own   = (rx_addr == own_addr_i);
  assign eq_zero  = is_all_zero({{(32-BYTE_W){1'b0}}, first_byte_i}, BYTE_W);
  assign eligible = first_vld_i && !mst_i && !free_fmt_i;
  assign hit_set  = eligible && eq_own;
  assign gc_set   = eligible && eq_zero;
  assign flag_clr = start_i || stop_i;

  assign slave_sel_o = hit_set || gc_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hit_o <= 1'b0;
      gen_call_o <= 1'b0;
    end else if (flag_clr) begin
      addr_hit_o <= 1'b0;
      gen_call_o <= 1'b0;
    end else begin
      if (hit_set) addr_hit_o <= 1'b1;
      if (gc_set)  gen_call_o <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_role_mst_flag.sv
module i2c_role_mst_flag (
  input  logic clk,
  input  logic rst,
  input  logic stop_i,
  input  logic arb_lost_i,
  input  logic sw_take_i,
  input  logic sw_mst_i,
  output logic mst_o
);

  logic drop;
  assign drop = stop_i || arb_lost_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_o <= 1'b0;
    end else if (drop) begin
      mst_o <= 1'b0;
    end else if (sw_take_i) begin
      mst_o <= sw_mst_i;
    end
  end

endmodule

// File: rtl/i2c_role_trx_flag.sv
module i2c_role_trx_flag (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  input  logic arb_lost_i,
  input  logic first_vld_i,
  input  logic rw_i,
  input  logic ack_i,
  input  logic mst_i,
  input  logic free_fmt_i,
  input  logic slave_sel_i,
  input  logic sw_take_i,
  input  logic sw_trx_i,
  output logic trx_o
);
  import i2c_role_pkg::*;

  logic     ack_pend;
  logic     rw_sent;
  trx_src_e src;

  // Hardware source selection, strongest first.
  always_comb begin
    src = TRX_HOLD;
    if (!free_fmt_i) begin
      if (stop_i || arb_lost_i)
        src = TRX_CLEAR;
      else if (slave_sel_i)
        src = TRX_SLAVE;
      else if (ack_i && mst_i && ack_pend)
        src = TRX_MSTR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_pend <= 1'b0;
      rw_sent  <= 1'b0;
    end else if (start_i || stop_i || arb_lost_i) begin
      ack_pend <= 1'b0;
    end else if (first_vld_i && mst_i) begin
      ack_pend <= 1'b1;
      rw_sent  <= rw_i;
    end else if (ack_i) begin
      ack_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trx_o <= 1'b0;
    end else begin
      unique case (src)
        TRX_CLEAR: trx_o <= 1'b0;
        TRX_SLAVE: trx_o <= rw_i;
        TRX_MSTR:  trx_o <= ~rw_sent;
        default:   if (sw_take_i) trx_o <= sw_trx_i;
      endcase
    end
  end

endmodule

// File: rtl/i2c_role_tracker.sv
module i2c_role_tracker #(
  parameter int unsigned ADDR_W = i2c_role_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr_i,
  input  logic              sw_mst_i,
  input  logic              sw_trx_i,
  input  logic              start_i,
  input  logic              first_vld_i,
  input  logic [ADDR_W:0]   first_byte_i,
  input  logic              ack_i,
  input  logic              stop_i,
  input  logic              arb_lost_i,
  input  logic              free_fmt_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              mst_o,
  output logic              trx_o,
  output logic              addr_hit_o,
  output logic              gen_call_o
);

  logic hw_evt;
  logic sw_take;
  logic slave_sel;

  assign hw_evt  = stop_i || arb_lost_i || first_vld_i || ack_i;
  assign sw_take = sw_wr_i && !hw_evt;

  i2c_role_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .first_vld_i  (first_vld_i),
    .first_byte_i (first_byte_i),
    .own_addr_i   (own_addr_i),
    .mst_i        (mst_o),
    .free_fmt_i   (free_fmt_i),
    .slave_sel_o  (slave_sel),
    .addr_hit_o   (addr_hit_o),
    .gen_call_o   (gen_call_o)
  );

  i2c_role_mst_flag u_mst (
    .clk        (clk),
    .rst        (rst),
    .stop_i     (stop_i),
    .arb_lost_i (arb_lost_i),
    .sw_take_i  (sw_take),
    .sw_mst_i   (sw_mst_i),
    .mst_o      (mst_o)
  );

  i2c_role_trx_flag u_trx (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .arb_lost_i  (arb_lost_i),
    .first_vld_i (first_vld_i),
    .rw_i        (first_byte_i[0]),
    .ack_i       (ack_i),
    .mst_i       (mst_o),
    .free_fmt_i  (free_fmt_i),
    .slave_sel_i (slave_sel),
    .sw_take_i   (sw_take),
    .sw_trx_i    (sw_trx_i),
    .trx_o       (trx_o)
  );

endmodule

// File: rtl/i2c_role_tracker_chk.sv
module i2c_role_tracker_chk #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_wr_i,
  input logic              sw_mst_i,
  input logic              start_i,
  input logic              first_vld_i,
  input logic [ADDR_W:0]   first_byte_i,
  input logic              ack_i,
  input logic              stop_i,
  input logic              arb_lost_i,
  input logic              free_fmt_i,
  input logic [ADDR_W-1:0] own_addr_i,
  input logic              mst_o,
  input logic              trx_o,
  input logic              addr_hit_o,
  input logic              gen_call_o
);

  logic slave_clean;
  assign slave_clean = first_vld_i && !mst_o && !free_fmt_i && !start_i && !stop_i && !arb_lost_i;

  // R3
  own_hit_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (slave_clean && first_byte_i[ADDR_W:1] == own_addr_i)
      |=> (addr_hit_o && trx_o == $past(first_byte_i[0])));

  // R4
  gen_call_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (slave_clean && first_byte_i == '0) |=> (gen_call_o && !trx_o));

  // R8
  drop_master_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_i || arb_lost_i) |=> !mst_o);

  // R8
  drop_trx_chk: assert property (@(posedge clk) disable iff (rst)
    ((stop_i || arb_lost_i) && !free_fmt_i) |=> !trx_o);

  // R9
  free_trx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (free_fmt_i && !sw_wr_i) |=> $stable(trx_o));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i || stop_i) |=> (!addr_hit_o && !gen_call_o));

  // R11
  write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_wr_i && !sw_mst_i && !stop_i && !arb_lost_i && (first_vld_i || ack_i))
      |=> (mst_o == $past(mst_o)));

endmodule

bind i2c_role_tracker i2c_role_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sw_wr_i      (sw_wr_i),
  .sw_mst_i     (sw_mst_i),
  .start_i      (start_i),
  .first_vld_i  (first_vld_i),
  .first_byte_i (first_byte_i),
  .ack_i        (ack_i),
  .stop_i       (stop_i),
  .arb_lost_i   (arb_lost_i),
  .free_fmt_i   (free_fmt_i),
  .own_addr_i   (own_addr_i),
  .mst_o        (mst_o),
  .trx_o        (trx_o),
  .addr_hit_o   (addr_hit_o),
  .gen_call_o   (gen_call_o)
);

// File: tb/tb_i2c_role_tracker.sv
module tb_i2c_role_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_wr = 0, sw_mst = 0, sw_trx = 0, start = 0, fvld = 0, ack = 0;
  logic stop = 0, arb = 0, free = 0;
  logic [AW:0]   fbyte = '0;
  logic [AW-1:0] own = 7'h3A;
  logic mst, trx, hit, gc;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural model state
  bit m_mst, m_trx, m_hit, m_gc, m_pend, m_rw;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_role_tracker #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .sw_wr_i(sw_wr), .sw_mst_i(sw_mst), .sw_trx_i(sw_trx),
    .start_i(start), .first_vld_i(fvld), .first_byte_i(fbyte), .ack_i(ack),
    .stop_i(stop), .arb_lost_i(arb), .free_fmt_i(free), .own_addr_i(own),
    .mst_o(mst), .trx_o(trx), .addr_hit_o(hit), .gen_call_o(gc)
  );

  task automatic model_step();
    bit hw, slave, n_mst, n_trx, n_hit, n_gc, n_pend, n_rw;
    if (rst) begin
      m_mst = 0; m_trx = 0; m_hit = 0; m_gc = 0; m_pend = 0; m_rw = 0;
      return;
    end
    hw = stop | arb | fvld | ack;
    slave = fvld && !m_mst && !free;
    n_mst = m_mst; n_trx = m_trx; n_hit = m_hit; n_gc = m_gc;
    n_pend = m_pend; n_rw = m_rw;
    if (stop || arb) n_mst = 0;
    else if (sw_wr && !hw) n_mst = sw_mst;
    if (free) begin
      if (sw_wr && !hw) n_trx = sw_trx;
    end else if (stop || arb) n_trx = 0;
    else if (slave && (fbyte[AW:1] == own || fbyte == 0)) n_trx = fbyte[0];
    else if (ack && m_mst && m_pend) n_trx = !m_rw;
    else if (sw_wr && !hw) n_trx = sw_trx;
    if (start || stop) begin n_hit = 0; n_gc = 0; end
    else begin
      if (slave && fbyte[AW:1] == own) n_hit = 1;
      if (slave && fbyte == 0) n_gc = 1;
    end
    if (start || stop || arb) n_pend = 0;
    else if (fvld && m_mst) begin n_pend = 1; n_rw = fbyte[0]; end
    else if (ack) n_pend = 0;
    m_mst = n_mst; m_trx = n_trx; m_hit = n_hit; m_gc = n_gc;
    m_pend = n_pend; m_rw = n_rw;
  endtask

  task automatic check1(string req, string name, logic act, bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic cyc(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check1(req, "mst_o", mst, m_mst);
    check1(req, "trx_o", trx, m_trx);
    check1(req, "addr_hit_o", hit, m_hit);
    check1(req, "gen_call_o", gc, m_gc);
    sw_wr = 0; start = 0; fvld = 0; ack = 0; stop = 0; arb = 0;
  endtask

  task automatic expect_now(string req, bit e_mst, bit e_trx, bit e_hit, bit e_gc);
    check1(req, "mst_o(dir)", mst, e_mst);
    check1(req, "trx_o(dir)", trx, e_trx);
    check1(req, "addr_hit_o(dir)", hit, e_hit);
    check1(req, "gen_call_o(dir)", gc, e_gc);
  endtask

  task automatic write(bit wm, bit wt);
    sw_wr = 1; sw_mst = wm; sw_trx = wt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc("R1"); cyc("R1");
    rst = 0;
    cyc("R1"); expect_now("R1", 0, 0, 0, 0);

    // slave, own address, read request -> transmitter
    start = 1; cyc("R10");
    fvld = 1; fbyte = {own, 1'b1}; cyc("R3"); expect_now("R3", 0, 1, 1, 0);
    stop = 1; cyc("R8"); expect_now("R8", 0, 0, 0, 0);
    // slave, own address, write -> receiver after sw sets trx
    write(0, 1); cyc("R2"); expect_now("R2", 0, 1, 0, 0);
    start = 1; cyc("R10");
    fvld = 1; fbyte = {own, 1'b0}; cyc("R3"); expect_now("R3", 0, 0, 1, 0);
    // new start clears hit
    start = 1; cyc("R10"); expect_now("R10", 0, 0, 0, 0);
    // general call after trx set by software
    write(0, 1); cyc("R2");
    start = 1; cyc("R10");
    fvld = 1; fbyte = 8'h00; cyc("R4"); expect_now("R4", 0, 0, 0, 1);
    start = 1; cyc("R10"); expect_now("R10", 0, 0, 0, 0);
    // non-matching address ignored
    write(0, 1); cyc("R2");
    fvld = 1; fbyte = {7'h11, 1'b0}; cyc("R5"); expect_now("R5", 0, 1, 0, 0);

    // master read: R/W=1, ack -> receiver
    write(1, 1); cyc("R2"); expect_now("R2", 1, 1, 0, 0);
    fvld = 1; fbyte = {7'h22, 1'b1}; cyc("R6"); expect_now("R6", 1, 1, 0, 0);
    ack = 1; cyc("R6"); expect_now("R6", 1, 0, 0, 0);
    ack = 1; cyc("R7"); expect_now("R7", 1, 0, 0, 0);
    // master write: R/W=0, no ack keeps trx, ack sets it
    write(1, 0); cyc("R2");
    start = 1; cyc("R10");
    fvld = 1; fbyte = {7'h22, 1'b0}; cyc("R7");
    cyc("R7"); cyc("R7"); expect_now("R7", 1, 0, 0, 0);
    ack = 1; cyc("R6"); expect_now("R6", 1, 1, 0, 0);
    // arbitration lost
    arb = 1; cyc("R8"); expect_now("R8", 0, 0, 0, 0);

    // write colliding with hardware events
    write(1, 1); fvld = 1; fbyte = {7'h55, 1'b0}; cyc("R11"); expect_now("R11", 0, 0, 0, 0);
    write(1, 1); stop = 1; cyc("R11"); expect_now("R11", 0, 0, 0, 0);

    // free data format
    free = 1;
    write(1, 1); cyc("R2");
    stop = 1; cyc("R9"); expect_now("R9", 0, 1, 0, 0);
    fvld = 1; fbyte = {own, 1'b0}; cyc("R9"); expect_now("R9", 0, 1, 0, 0);
    fvld = 1; fbyte = 8'h00; cyc("R9"); expect_now("R9", 0, 1, 0, 0);
    write(1, 0); cyc("R2");
    fvld = 1; fbyte = {7'h01, 1'b0}; cyc("R9");
    ack = 1; cyc("R9"); expect_now("R9", 1, 0, 0, 0);
    arb = 1; cyc("R9"); expect_now("R9", 0, 0, 0, 0);
    free = 0;

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      sw_wr = (r < 15); sw_mst = $urandom_range(0, 1); sw_trx = $urandom_range(0, 1);
      start = ($urandom_range(0, 99) < 10);
      fvld  = ($urandom_range(0, 99) < 15);
      ack   = ($urandom_range(0, 99) < 15);
      stop  = ($urandom_range(0, 99) < 5);
      arb   = ($urandom_range(0, 99) < 4);
      case ($urandom_range(0, 3))
        0: fbyte = {own, 1'($urandom_range(0, 1))};
        1: fbyte = 8'h00;
        default: fbyte = 8'($urandom_range(0, 255));
      endcase
      if ((i % 500) == 0) free = $urandom_range(0, 1);
      cyc("R11");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule